// File: doc/BRIEF.md
# Strobe-Serviced Watchdog Reset Generator

This block supervises a processor and pulls it into reset when its software stops servicing it. It counts a 1 ms timebase tick. Software restarts the count by driving a falling edge on the strobe input. If no such edge arrives before the selected period runs out, the block raises its reset outputs for a fixed hold time. After the hold it releases reset and begins a new count. A 2-bit select code picks one of three periods: 150, 610 or 1200 ticks.

A power-good level comes in already clean and synchronous. While it is low, reset stays asserted and the count is held at zero. When it returns, the same minimum hold applies. The strobe edge is caught asynchronously, so a pulse shorter than a clock period is still seen. The catch is then synchronised into the clock domain. No input can turn the supervision off.

Top module: `wdog_rst_gen`

## Requirements
- R1: After power-good is high, reset is held asserted for exactly HOLD_MS ticks (default 250) and is released on the clock edge that samples the last of those ticks. This holds after the asynchronous reset, after power-good rises and after a time-out.
- R2: With no service, reset rises on the clock edge that samples the Nth tick after the count restarted. N is 150 for select 00, 610 for select 01 and 1200 for select 10.
- R3: Select code 11 gives the same period as code 01.
- R4: Only a high-to-low strobe transition services the watchdog. It restarts the count from zero on the third rising clock edge after the transition. A strobe held low or high, or a low-to-high transition, does not restart the count.
- R5: Strobe transitions that occur while reset is asserted change neither the hold length nor the next time-out.
- R6: While power-good is low, reset is asserted from the next clock edge onward and the time-out count stays at zero. A full hold follows when power-good returns.
- R7: The select code is sampled only when a count restarts, either by service or by the end of a hold. A change in the middle of a period takes effect at the next restart.
- R8: A strobe low pulse shorter than one clock period is detected as a service.
- R9: reset_n_o is always the complement of reset_o.
- R10: If a service and the tick that would expire the period are sampled on the same clock edge, the service wins. No reset occurs and the count restarts from zero.
- R11: The watchdog has no disable. Without service, time-out and hold repeat indefinitely.
- R12: While rst_n is low, reset_o is high and reset_n_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low initialisation |
| tick_i | input | 1 | One-cycle pulse per millisecond |
| strobe_i | input | 1 | Service strobe; falling edge services the watchdog |
| pwr_good_i | input | 1 | Synchronous supply-in-tolerance level |
| period_sel_i | input | 2 | Time-out select code |
| reset_o | output | 1 | Active-high processor reset |
| reset_n_o | output | 1 | Active-low processor reset |

## Verification
Two events can land on the same clock edge: a service arriving from the synchroniser, and the tick that would end the period. The bench provokes this by timing a falling strobe so that its synchronised pulse reaches the core on the same edge as that expiring tick. It then requires reset to stay low and a full fresh period to follow. A small configuration (periods 6, 10 and 14, hold 5) is swept through every select code. The expected tick counts come from that arithmetic.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } wd_state_e;

    typedef enum logic [1:0] {
        SEL_SHORT = 2'b00,
        SEL_MID   = 2'b01,
        SEL_LONG  = 2'b10,
        SEL_ALT   = 2'b11
    } wd_sel_e;

endpackage

// File: rtl/wdog_strobe_cap.sv
module wdog_strobe_cap #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic fall_o
);
    localparam int SW = SYNC_STAGES + 1;

    // Toggle on every falling strobe edge; survives pulses shorter than clk.
    logic          tog_q;
    logic [SW-1:0] sync_d, sync_q;

    always_ff @(negedge strobe_i or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= ~tog_q;
    end

    always_comb begin
        sync_d = {sync_q[SW-2:0], tog_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // A change between the last two stages marks one captured edge.
    assign fall_o = sync_q[SW-1] ^ sync_q[SW-2];

endmodule

// File: rtl/wdog_period_dec.sv
module wdog_period_dec
    import wdog_pkg::*;
#(
    parameter int P_SHORT = 150,
    parameter int P_MID   = 610,
    parameter int P_LONG  = 1200,
    parameter int CW      = 11
) (
    input  logic [1:0]    sel_i,
    output logic [CW-1:0] limit_o
);
    always_comb begin
        case (wd_sel_e'(sel_i))
            SEL_SHORT: limit_o = CW'(P_SHORT);
            SEL_LONG:  limit_o = CW'(P_LONG);
            default:   limit_o = CW'(P_MID);
        endcase
    end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int HOLD_MS = 250,
    parameter int CW      = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          pwr_good_i,
    input  logic          service_i,
    input  logic [CW-1:0] limit_i,
    output logic          reset_o
);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_MS - 1);

    typedef struct packed {
        wd_state_e     st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
    } core_s;

    core_s q, d;

    always_comb begin
        d = q;
        if (!pwr_good_i) begin
            d.st  = ST_HOLD;
            d.cnt = '0;
        end else begin
            case (q.st)
                ST_HOLD: begin
                    // Strobe deliberately not looked at while in hold.
                    if (tick_i) begin
                        if (q.cnt == HOLD_LAST) begin
                            d.st  = ST_RUN;
                            d.cnt = '0;
                            d.lim = limit_i;
                        end else begin
                            d.cnt = q.cnt + CW'(1);
                        end
                    end
                end
                default: begin
                    // Service outranks an expiring tick on the same edge.
                    if (service_i) begin
                        d.cnt = '0;
                        d.lim = limit_i;
                    end else if (tick_i) begin
                        if (q.cnt == q.lim - CW'(1)) begin
                            d.st  = ST_HOLD;
                            d.cnt = '0;
                        end else begin
                            d.cnt = q.cnt + CW'(1);
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= ST_HOLD;
            q.cnt <= '0;
            q.lim <= '0;
        end else begin
            q <= d;
        end
    end

    assign reset_o = (q.st == ST_HOLD);

endmodule

// File: rtl/wdog_rst_gen.sv
module wdog_rst_gen #(
    parameter int PERIOD_SHORT_MS = 150,
    parameter int PERIOD_MID_MS   = 610,
    parameter int PERIOD_LONG_MS  = 1200,
    parameter int HOLD_MS         = 250,
    parameter int SYNC_STAGES     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       strobe_i,
    input  logic       pwr_good_i,
    input  logic [1:0] period_sel_i,
    output logic       reset_o,
    output logic       reset_n_o
);
    localparam int MAX_A  = (PERIOD_SHORT_MS > PERIOD_MID_MS) ? PERIOD_SHORT_MS : PERIOD_MID_MS;
    localparam int MAX_B  = (PERIOD_LONG_MS > HOLD_MS) ? PERIOD_LONG_MS : HOLD_MS;
    localparam int MAX_MS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW     = $clog2(MAX_MS + 1);

    logic          service;
    logic [CW-1:0] limit;
    logic          rst_int;

    wdog_strobe_cap #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .fall_o   (service)
    );

    wdog_period_dec #(
        .P_SHORT (PERIOD_SHORT_MS),
        .P_MID   (PERIOD_MID_MS),
        .P_LONG  (PERIOD_LONG_MS),
        .CW      (CW)
    ) u_dec (
        .sel_i   (period_sel_i),
        .limit_o (limit)
    );

    wdog_core #(.HOLD_MS(HOLD_MS), .CW(CW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .pwr_good_i (pwr_good_i),
        .service_i  (service),
        .limit_i    (limit),
        .reset_o    (rst_int)
    );

    assign reset_o   = rst_int;
    assign reset_n_o = ~rst_int;

endmodule

// File: rtl/wdog_rst_gen_chk.sv
module wdog_rst_gen_chk #(
    parameter int HOLD_MS = 250,
    parameter int CW      = 11
) (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic pwr_good_i,
    input logic reset_o,
    input logic reset_n_o
);
    // Ticks seen during the current hold, counted from the ports only.
    logic [CW:0] hold_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      hold_seen <= '0;
        else if (!reset_o || !pwr_good_i) hold_seen <= '0;
        else if (tick_i)                  hold_seen <= hold_seen + (CW+1)'(1);
    end

    a_r9_complement: assert property (@(posedge clk) disable iff (!rst_n)
        reset_o != reset_n_o);

    a_r6_pg_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good_i |=> reset_o);

    a_r1_hold_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_o) |-> (hold_seen == (CW+1)'(HOLD_MS)));

    a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_o) |-> ($past(tick_i) || !$past(pwr_good_i)));

    a_r5_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_o) |-> ($past(tick_i) && $past(pwr_good_i)));

endmodule

bind wdog_rst_gen wdog_rst_gen_chk #(.HOLD_MS(HOLD_MS), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .pwr_good_i (pwr_good_i),
    .reset_o    (reset_o),
    .reset_n_o  (reset_n_o)
);

// File: tb/wdog_rst_gen_bench.sv
module wdog_rst_gen_bench;
    localparam int PS = 6, PM = 10, PL = 14, HM = 5;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, strobe = 1'b1, pwr_good = 1'b1;
    logic [1:0] sel = 2'b00;
    logic rst_hi, rst_lo;
    int n_checks = 0, n_fail = 0, comp_bad = 0;
    bit finished = 1'b0;

    wdog_rst_gen #(.PERIOD_SHORT_MS(PS), .PERIOD_MID_MS(PM), .PERIOD_LONG_MS(PL),
                   .HOLD_MS(HM), .SYNC_STAGES(2)) u_wdog_rst_gen (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .strobe_i(strobe),
        .pwr_good_i(pwr_good), .period_sel_i(sel),
        .reset_o(rst_hi), .reset_n_o(rst_lo));

    always #10 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk) tick = 1'b0;
            @(negedge clk) tick = 1'b1;
        end
    end

    always @(negedge clk) if (rst_n && (rst_hi === rst_lo)) comp_bad++;

    function automatic int exp_lim(input int s);
        case (s)
            0: return PS;
            2: return PL;
            default: return PM;
        endcase
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick_edge();
        do @(posedge clk); while (tick !== 1'b1);
    endtask

    // Count ticks until reset_o reaches lvl; ends at negedge after that tick edge.
    task automatic ticks_until(input logic lvl, output int n);
        n = 0;
        forever begin
            wait_tick_edge();
            n++;
            @(negedge clk);
            if (rst_hi === lvl || n > 200) break;
        end
    endtask

    task automatic short_strobe();
        strobe = 1'b0;
        #3 strobe = 1'b1;
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_up();
    end

    initial begin
        int n, bad;
        // R12: reset state
        repeat (3) @(negedge clk);
        check_eq("R12 reset_o during rst_n", int'(rst_hi), 1);
        check_eq("R12 reset_n_o during rst_n", int'(rst_lo), 0);
        rst_n = 1'b1;
        ticks_until(1'b0, n); check_eq("R1 initial hold", n, HM);
        ticks_until(1'b1, n); check_eq("R2 first timeout sel0", n, PS);

        // R2 R3 R11: sweep all select codes, repeated unserviced cycles
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            ticks_until(1'b0, n); check_eq("R1 hold after timeout", n, HM);
            ticks_until(1'b1, n); check_eq("R2 R3 R11 period for select", n, exp_lim(s));
        end

        // R4 R8: keep-alive with short falling pulses
        sel = 2'b01;
        ticks_until(1'b0, n);
        bad = 0;
        for (int k = 0; k < 6; k++) begin
            short_strobe();
            repeat (PM - 1) begin
                wait_tick_edge(); @(negedge clk);
                if (rst_hi !== 1'b0) bad++;
            end
        end
        check_eq("R4 R8 serviced no reset", bad, 0);
        short_strobe();
        ticks_until(1'b1, n); check_eq("R4 service restarts from zero", n, PM);

        // R4: static low and rising edge do not service
        ticks_until(1'b0, n);
        strobe = 1'b0;
        ticks_until(1'b1, n); check_eq("R4 static low", n, PM);
        ticks_until(1'b0, n);
        repeat (3) begin wait_tick_edge(); @(negedge clk); end
        strobe = 1'b1;
        ticks_until(1'b1, n); check_eq("R4 rising edge ignored", n + 3, PM);

        // R5: strobes during hold ignored
        n = 0;
        forever begin
            wait_tick_edge(); n++; @(negedge clk);
            if (rst_hi !== 1'b1 || n > 200) break;
            short_strobe();
        end
        check_eq("R5 hold with strobes", n, HM);
        ticks_until(1'b1, n); check_eq("R5 period after strobed hold", n, PM);

        // R7: select sampled at restart only
        sel = 2'b00;
        ticks_until(1'b0, n);
        sel = 2'b10;
        ticks_until(1'b1, n); check_eq("R7 mid-period change ignored", n, PS);
        ticks_until(1'b0, n);
        ticks_until(1'b1, n); check_eq("R7 new select at next restart", n, PL);

        // R10: service coincides with expiring tick
        sel = 2'b01;
        ticks_until(1'b0, n);
        repeat (PM - 1) begin wait_tick_edge(); @(negedge clk); end
        @(negedge clk);
        short_strobe();
        wait_tick_edge(); @(negedge clk);
        check_eq("R10 no reset on coincident service", int'(rst_hi), 0);
        ticks_until(1'b1, n); check_eq("R10 fresh period after coincidence", n, PM);

        // R6: power-good low
        ticks_until(1'b0, n);
        repeat (2) begin wait_tick_edge(); @(negedge clk); end
        pwr_good = 1'b0;
        @(negedge clk);
        check_eq("R6 reset next edge after pg low", int'(rst_hi), 1);
        bad = 0;
        repeat (3 * HM) begin
            wait_tick_edge(); @(negedge clk);
            if (rst_hi !== 1'b1) bad++;
            short_strobe();
        end
        check_eq("R6 reset held while pg low", bad, 0);
        wait_tick_edge(); @(negedge clk);
        pwr_good = 1'b1;
        ticks_until(1'b0, n); check_eq("R6 R1 hold after pg return", n, HM);
        ticks_until(1'b1, n); check_eq("R6 count was zero", n, PM);

        check_eq("R9 complementary outputs", comp_bad, 0);
        finish_up();
    end
endmodule